// File: doc/BRIEF.md
# Flash Card Serial Host Interface

This block is the host end of a three-wire serial link to a removable flash card. It produces a shift clock and a bus-state line that marks the two phases of every packet. It also drives a half-duplex data line, using a separate output enable, and a direction signal for an external level-shifting buffer. A card-presence input is synchronised and watched for changes. Software works through four byte-wide registers. Through them it loads a command byte and a transmit byte, picks a clock divider, starts a read or a write packet, reads back the received byte and polls or clears the status flags.

A packet begins with a command phase. In this phase the bus-state line is high and the eight command bits leave MSB first. The data phase follows with the bus-state line low. A write packet then shifts out the transmit byte. A read packet first releases the data line for one full shift-clock period so the card can take it over. It then samples eight bits on rising edges. Every output changes only in the system cycle where the shift clock falls. When the packet completes, a sticky done flag is set. A change of card presence sets a second sticky flag. The interrupt output is the OR of the two flags.

Top module: `card_serial_host`

## Requirements
- R1: After reset, `card_sclk`, `card_bs`, `card_sd_out`, `card_sd_oe`, `card_dir` and `irq` are 0, and the status register (offset 3) reads 0x00 while the card input is low.
- R2: Control register (offset 0) bits [1:0] hold a divider code d. While a packet runs, each high phase and each low phase of `card_sclk` lasts 2^d system cycles, so d = 0, 1, 2, 3 gives half-periods of 1, 2, 4 and 8 cycles.
- R3: Writing the control register with bit 2 = 1 and bit 3 = 0 starts a write packet. One idle rising edge comes first. Then the 8 command bits (offset 1) and the 8 transmit bits (offset 2) follow, each MSB first. A bit is presented at a falling edge and is valid at the next rising edge. `card_bs` is 1 at the 8 command rising edges and 0 at the 8 data rising edges, and `card_sd_oe` is 1 at all 16. The packet produces exactly 17 rising edges.
- R4: Writing the control register with bit 2 = 1 and bit 3 = 1 starts a read packet. After the 8 command bits, `card_sd_oe` drops together with `card_bs`, and one full shift-clock period with a rising edge passes before sampling starts. Eight `card_sd_in` bits are then sampled on the next 8 rising edges, MSB first. The received byte reads at offset 2 once the packet ends. The packet produces exactly 18 rising edges.
- R5: `card_bs`, `card_sd_out`, `card_sd_oe` and `card_dir` change only in the system cycle in which `card_sclk` goes from 1 to 0.
- R6: `card_dir` equals `card_sd_oe` in every cycle.
- R7: Status bit 0 (busy) is 1 from the start write until the falling edge that ends the last data bit. In that same cycle status bit 1 (done) is set and the clock stops low. Writes to offsets 0, 1 and 2 while busy are ignored, including a start request.
- R8: `card_det` passes through a two-stage synchroniser. Status bit 3 shows the synchronised presence. Any change of it sets the sticky status bit 2. `irq` equals status bit 1 OR status bit 2.
- R9: Writing offset 3 with bit 1 or bit 2 set to 1 clears that flag. If a set event falls in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset for both write and read |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Registered read data for `addr`, valid one cycle later |
| irq | output | 1 | Done flag OR presence-change flag |
| card_sclk | output | 1 | Shift clock to the card |
| card_bs | output | 1 | Bus-state line marking the packet phases |
| card_sd_out | output | 1 | Data line output value |
| card_sd_oe | output | 1 | Data line output enable |
| card_dir | output | 1 | Direction indicator for the external buffer, 1 while the host drives |
| card_sd_in | input | 1 | Data line input value |
| card_det | input | 1 | Asynchronous card presence input, 1 = card present |

## Verification
The done flag can be set by the packet engine in the same cycle that software writes 1 to clear it. With the fastest divider setting, a write packet ends a fixed number of cycles after the start write is captured. The bench counts those cycles and lands the clear write on exactly that edge. It then reads the status register. The done bit must still read 1, which shows that the set takes priority. The order matters here: a clear captured one cycle later would leave the bit at 0.

// File: rtl/csh_pkg.sv
package csh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CMD,
    ST_TURN,
    ST_DATA
  } seq_state_t;

  localparam int REG_CTRL = 0;
  localparam int REG_CMD  = 1;
  localparam int REG_DATA = 2;
  localparam int REG_STAT = 3;

  localparam int STAT_BUSY    = 0;
  localparam int STAT_DONE    = 1;
  localparam int STAT_CHANGE  = 2;
  localparam int STAT_PRESENT = 3;

endpackage

// File: rtl/csh_clkdiv.sv
module csh_clkdiv #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt
);

  localparam int MAX_HALF = 2 ** ((2 ** SEL_W) - 1);
  localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             term;

  always_comb begin
    lim      = CNT_W'((32'd1 << sel) - 32'd1);
    term     = run && (cnt == lim);
    rise_evt = term && !sclk;
    fall_evt = term && sclk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (term) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: between ticks the shift clock holds its level
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (run && !term) |=> $stable(sclk));

endmodule

// File: rtl/csh_presence.sv
module csh_presence #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic present,
  output logic change
);

  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], din};
      prev <= sr[STAGES-1];
    end
  end

  assign present = sr[STAGES-1];
  assign change  = sr[STAGES-1] ^ prev;

endmodule

// File: rtl/csh_engine.sv
module csh_engine
  import csh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_mode,
  input  logic [DATA_W-1:0] cmd,
  input  logic [DATA_W-1:0] txd,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              sd_in,
  output logic              run,
  output logic              bs,
  output logic              sd_out,
  output logic              oe,
  output logic              dir,
  output logic [DATA_W-1:0] rxd,
  output logic              finish_evt
);

  localparam int BC_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int MSB  = DATA_W - 1;

  seq_state_t       state;
  logic [BC_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] txq;
  logic [DATA_W-1:0] rxsh;
  logic             mode_q;

  assign finish_evt = fall_evt && (state == ST_DATA) && (bitcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txq    <= '0;
      rxsh   <= '0;
      rxd    <= '0;
      mode_q <= 1'b0;
      run    <= 1'b0;
      bs     <= 1'b0;
      sd_out <= 1'b0;
      oe     <= 1'b0;
      dir    <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state  <= ST_LEAD;
        run    <= 1'b1;
        mode_q <= rd_mode;
        shreg  <= cmd;
        txq    <= txd;
      end
    end else begin
      if (rise_evt && (state == ST_DATA) && mode_q)
        rxsh <= {rxsh[DATA_W-2:0], sd_in};
      if (fall_evt) begin
        case (state)
          ST_LEAD: begin
            state  <= ST_CMD;
            bs     <= 1'b1;
            oe     <= 1'b1;
            dir    <= 1'b1;
            sd_out <= shreg[MSB];
            shreg  <= shreg << 1;
            bitcnt <= BC_W'(DATA_W - 1);
          end
          ST_CMD: begin
            if (bitcnt == '0) begin
              bs     <= 1'b0;
              bitcnt <= BC_W'(DATA_W - 1);
              if (mode_q) begin
                state  <= ST_TURN;
                oe     <= 1'b0;
                dir    <= 1'b0;
                sd_out <= 1'b0;
              end else begin
                state  <= ST_DATA;
                sd_out <= txq[MSB];
                shreg  <= txq << 1;
              end
            end else begin
              sd_out <= shreg[MSB];
              shreg  <= shreg << 1;
              bitcnt <= bitcnt - 1'b1;
            end
          end
          ST_TURN: begin
            state <= ST_DATA;
          end
          ST_DATA: begin
            if (bitcnt == '0) begin
              state  <= ST_IDLE;
              run    <= 1'b0;
              oe     <= 1'b0;
              dir    <= 1'b0;
              sd_out <= 1'b0;
              if (mode_q) rxd <= rxsh;
            end else begin
              if (!mode_q) begin
                sd_out <= shreg[MSB];
                shreg  <= shreg << 1;
              end
              bitcnt <= bitcnt - 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R6: buffer direction and line enable move as a pair
  a_r6_dir_tracks_oe: assert property (@(posedge clk) disable iff (rst)
    dir == oe);

  // R4: the host never drives while it samples read data
  a_r4_released_on_sample: assert property (@(posedge clk) disable iff (rst)
    (rise_evt && (state == ST_DATA) && mode_q) |-> !oe);

endmodule

// File: rtl/card_serial_host.sv
module card_serial_host
  import csh_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              card_sclk,
  output logic              card_bs,
  output logic              card_sd_out,
  output logic              card_sd_oe,
  output logic              card_dir,
  input  logic              card_sd_in,
  input  logic              card_det
);

  localparam int CTRL_START = SEL_W;
  localparam int CTRL_READ  = SEL_W + 1;

  logic [SEL_W-1:0]  div_sel;
  logic              rd_mode;
  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_byte;
  logic              done_flag;
  logic              chg_flag;
  logic              busy;
  logic              rise_evt;
  logic              fall_evt;
  logic              finish_evt;
  logic              present;
  logic              change;

  logic wr_ctrl, wr_cmd, wr_data, wr_stat, start;

  always_comb begin
    wr_ctrl = wr_en && !busy && (addr == ADDR_W'(REG_CTRL));
    wr_cmd  = wr_en && !busy && (addr == ADDR_W'(REG_CMD));
    wr_data = wr_en && !busy && (addr == ADDR_W'(REG_DATA));
    wr_stat = wr_en && (addr == ADDR_W'(REG_STAT));
    start   = wr_ctrl && wdata[CTRL_START];
  end

  csh_clkdiv #(.SEL_W(SEL_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .sel      (div_sel),
    .sclk     (card_sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  csh_engine #(.DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .rd_mode    (wdata[CTRL_READ]),
    .cmd        (cmd_q),
    .txd        (tx_q),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .sd_in      (card_sd_in),
    .run        (busy),
    .bs         (card_bs),
    .sd_out     (card_sd_out),
    .oe         (card_sd_oe),
    .dir        (card_dir),
    .rxd        (rx_byte),
    .finish_evt (finish_evt)
  );

  csh_presence #(.STAGES(SYNC_STAGES)) u_det (
    .clk     (clk),
    .rst     (rst),
    .din     (card_det),
    .present (present),
    .change  (change)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_sel   <= '0;
      rd_mode   <= 1'b0;
      cmd_q     <= '0;
      tx_q      <= '0;
      done_flag <= 1'b0;
      chg_flag  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        div_sel <= wdata[SEL_W-1:0];
        rd_mode <= wdata[CTRL_READ];
      end
      if (wr_cmd)  cmd_q <= wdata;
      if (wr_data) tx_q  <= wdata;
      if (finish_evt)                    done_flag <= 1'b1;
      else if (wr_stat && wdata[STAT_DONE]) done_flag <= 1'b0;
      if (change)                          chg_flag <= 1'b1;
      else if (wr_stat && wdata[STAT_CHANGE]) chg_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (addr)
        ADDR_W'(REG_CTRL): begin
          rdata[SEL_W-1:0] <= div_sel;
          rdata[CTRL_READ] <= rd_mode;
        end
        ADDR_W'(REG_CMD):  rdata <= cmd_q;
        ADDR_W'(REG_DATA): rdata <= rx_byte;
        default: begin
          rdata[STAT_BUSY]    <= busy;
          rdata[STAT_DONE]    <= done_flag;
          rdata[STAT_CHANGE]  <= chg_flag;
          rdata[STAT_PRESENT] <= present;
        end
      endcase
    end
  end

  assign irq = done_flag | chg_flag;

  // R5: the phase line only moves on a falling shift-clock edge
  a_r5_bs_on_fall: assert property (@(posedge clk) disable iff (rst)
    $changed(card_bs) |-> $fell(card_sclk));

  // R5: data value and enable only move on a falling shift-clock edge
  a_r5_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($changed(card_sd_out) || $changed(card_sd_oe)) |-> $fell(card_sclk));

  // R7: busy falls exactly when done is raised, with the clock parked low
  a_r7_done_with_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done_flag && !card_sclk));

  // R8: the change flag stays until software clears it
  a_r8_change_sticky: assert property (@(posedge clk) disable iff (rst)
    (chg_flag && !(wr_stat && wdata[STAT_CHANGE])) |=> chg_flag);

endmodule

// File: tb/card_serial_host_test.sv
module card_serial_host_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic       card_sclk, card_bs, card_sd_out, card_sd_oe, card_dir;
  logic       card_sd_in = 1'b0;
  logic       card_det = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  card_serial_host uut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr), .wdata (wdata),
    .rdata (rdata), .irq (irq), .card_sclk (card_sclk), .card_bs (card_bs),
    .card_sd_out (card_sd_out), .card_sd_oe (card_sd_oe), .card_dir (card_dir),
    .card_sd_in (card_sd_in), .card_det (card_det)
  );

  // line monitor and card model, sampled away from the active edge
  logic rb_bs [0:31];
  logic rb_sd [0:31];
  logic rb_oe [0:31];
  int   pkt_rise = 0;
  int   exp_half = 1;
  int   hi_len = 0;
  int   lo_len = 0;
  int   width_err = 0;
  int   edge_err = 0;
  int   pair_err = 0;
  bit   turn_seen = 0;
  int   drv_idx = 0;
  logic [7:0] card_byte = 8'h00;
  logic prev_sclk = 1'b0;
  logic [3:0] prev_vec = 4'h0;

  always @(negedge clk) begin
    if (!rst) begin
      if (card_sclk && !prev_sclk) begin
        if (pkt_rise < 32) begin
          rb_bs[pkt_rise] = card_bs;
          rb_sd[pkt_rise] = card_sd_out;
          rb_oe[pkt_rise] = card_sd_oe;
        end
        if (pkt_rise != 0 && lo_len != exp_half) width_err++;
        pkt_rise++;
        lo_len = 0;
      end
      if (!card_sclk && prev_sclk) begin
        if (hi_len != exp_half) width_err++;
        hi_len = 0;
        if (!card_bs && !card_sd_oe) begin
          if (!turn_seen) turn_seen = 1;
          else begin
            if (drv_idx < 8) card_sd_in = card_byte[7-drv_idx];
            else card_sd_in = 1'b0;
            drv_idx++;
          end
        end
      end
      if (card_sclk) hi_len++; else lo_len++;
      if ({card_bs, card_sd_oe, card_dir, card_sd_out} != prev_vec && !(prev_sclk && !card_sclk))
        edge_err++;
      if (card_dir != card_sd_oe) pair_err++;
    end
    prev_sclk = card_sclk;
    prev_vec  = {card_bs, card_sd_oe, card_dir, card_sd_out};
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_read(2'd3, s);
      if (!s[0]) break;
    end
  endtask

  task automatic arm_monitor(input int sel, input logic [7:0] byte_from_card);
    pkt_rise  = 0;
    exp_half  = 1 << sel;
    turn_seen = 0;
    drv_idx   = 0;
    card_byte = byte_from_card;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {card_sclk, card_bs, card_sd_out, card_sd_oe, card_dir, irq}, 0, "outputs after reset");
    reg_read(2'd3, s);
    chk("R1", s, 8'h00, "status after reset");
  endtask

  task automatic t_write(input int sel, input logic [7:0] c, input logic [7:0] d);
    logic [7:0] s;
    int w0, e0, p0, bad;
    reg_write(2'd1, c);
    reg_write(2'd2, d);
    reg_write(2'd3, 8'h02);
    arm_monitor(sel, 8'h00);
    w0 = width_err; e0 = edge_err; p0 = pair_err;
    reg_write(2'd0, 8'h04 | 8'(sel));
    wait_idle();
    chk("R3", pkt_rise, 17, "write packet rising edges");
    bad = 0;
    if (rb_bs[0] || rb_oe[0]) bad++;
    for (int i = 0; i < 8; i++) begin
      if (rb_sd[1+i] != c[7-i] || !rb_bs[1+i] || !rb_oe[1+i]) bad++;
      if (rb_sd[9+i] != d[7-i] || rb_bs[9+i] || !rb_oe[9+i]) bad++;
    end
    chk("R3", bad, 0, "write packet bit/phase mismatches");
    chk("R2", width_err - w0, 0, "shift clock half-period errors");
    chk("R5", edge_err - e0, 0, "outputs changed off a falling edge");
    chk("R6", pair_err - p0, 0, "dir differs from oe");
    reg_read(2'd3, s);
    chk("R7", {s[1], s[0]}, 2'b10, "done set, busy clear after write");
    chk("R8", irq, 1, "irq follows done");
    chk("R7", card_sclk, 0, "clock parked low");
  endtask

  task automatic t_read(input int sel, input logic [7:0] c, input logic [7:0] cb);
    logic [7:0] s;
    int w0, e0, bad;
    reg_write(2'd1, c);
    reg_write(2'd3, 8'h02);
    arm_monitor(sel, cb);
    w0 = width_err; e0 = edge_err;
    reg_write(2'd0, 8'h0C | 8'(sel));
    wait_idle();
    chk("R4", pkt_rise, 18, "read packet rising edges");
    bad = 0;
    for (int i = 0; i < 8; i++)
      if (rb_sd[1+i] != c[7-i] || !rb_bs[1+i] || !rb_oe[1+i]) bad++;
    chk("R3", bad, 0, "read packet command bits");
    chk("R4", {rb_bs[9], rb_oe[9]}, 0, "line released during turnaround");
    bad = 0;
    for (int i = 10; i < 18; i++) if (rb_bs[i] || rb_oe[i]) bad++;
    chk("R4", bad, 0, "host drive during data sampling");
    reg_read(2'd2, s);
    chk("R4", s, cb, "received byte");
    chk("R2", width_err - w0, 0, "read half-period errors");
    chk("R5", edge_err - e0, 0, "read outputs off a falling edge");
    reg_read(2'd3, s);
    chk("R7", {s[1], s[0]}, 2'b10, "done after read");
  endtask

  task automatic t_busy_start();
    logic [7:0] s;
    reg_write(2'd1, 8'h3C);
    arm_monitor(3, 8'h00);
    reg_write(2'd0, 8'h07);
    repeat (20) @(negedge clk);
    reg_read(2'd3, s);
    chk("R7", s[0], 1, "busy during packet");
    reg_write(2'd0, 8'h0D);
    reg_write(2'd1, 8'hEE);
    wait_idle();
    repeat (50) @(negedge clk);
    chk("R7", pkt_rise, 17, "start while busy ignored");
    chk("R7", card_sclk, 0, "no second packet");
    reg_read(2'd0, s);
    chk("R7", s, 8'h03, "control write while busy ignored");
    reg_read(2'd1, s);
    chk("R7", s, 8'h3C, "command write while busy ignored");
  endtask

  task automatic t_clear();
    logic [7:0] s;
    reg_write(2'd3, 8'h02);
    reg_read(2'd3, s);
    chk("R9", s[1], 0, "done cleared by write-one");
    chk("R9", irq, 0, "irq low after clear");
  endtask

  task automatic t_race();
    logic [7:0] s;
    reg_write(2'd3, 8'h06);
    arm_monitor(0, 8'h00);
    reg_write(2'd0, 8'h04);
    repeat (33) @(negedge clk);
    wr_en = 1'b1; addr = 2'd3; wdata = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    reg_read(2'd3, s);
    chk("R9", {s[1], s[0]}, 2'b10, "set wins over same-cycle clear");
  endtask

  task automatic t_card();
    logic [7:0] s;
    reg_write(2'd3, 8'h06);
    @(negedge clk);
    card_det = 1'b1;
    repeat (4) @(negedge clk);
    reg_read(2'd3, s);
    chk("R8", {s[3], s[2]}, 2'b11, "insert: present and change");
    chk("R8", irq, 1, "irq on insertion");
    reg_write(2'd3, 8'h04);
    reg_read(2'd3, s);
    chk("R9", {s[3], s[2]}, 2'b10, "change cleared, presence kept");
    chk("R8", irq, 0, "irq low after clear");
    card_det = 1'b0;
    repeat (4) @(negedge clk);
    reg_read(2'd3, s);
    chk("R8", {s[3], s[2]}, 2'b01, "removal: absent and change");
  endtask

  initial begin
    t_reset();
    t_write(0, 8'hA5, 8'h3C);
    t_write(2, 8'h81, 8'hFE);
    t_read(1, 8'h5A, 8'hC3);
    t_read(3, 8'hF0, 8'h01);
    t_clear();
    t_busy_start();
    t_race();
    t_card();
    chk("R6", pair_err, 0, "dir/oe mismatch over run");
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule